// File: doc/BRIEF.md
# SPI Word FIFO and Event Status Unit

This unit holds the transmit and receive word queues for one SPI channel and the small register set that software uses to watch them. A 32-bit register bus on one side writes transmit words, pops receive words, reads both queue levels in one packed word, and services six status bits. On the other side the serial engine pulls transmit words and delivers received words through single-cycle strobes. It also signals the end of a transfer and whether a command is in progress.

The unit flags a transmit underflow when the engine asks for a word that is not there during a transmitting command. It flags a receive overflow when the engine delivers a word into a full queue; that word is dropped. It also raises threshold events from two programmable levels. Events are sticky until software writes ones over them. A single interrupt line is the OR of the enabled events. Bus reads are combinational. A read of the receive data offset removes the word that it returns at the next clock edge.

Top module: `spi_wordq_status`

## Requirements
- R1: Each queue holds DEPTH (8) words of DW (32) bits. A read of offset 0x18 returns the receive level in bits [3:0] and the transmit level in bits [7:4], with all other bits zero.
- R2: A bus write to offset 0x1C appends one word to the transmit queue, and a write to a full queue is ignored. When `eng_tx_req` is high and the queue is not empty, `eng_tx_ack` is high in the same cycle, `eng_tx_word` carries the oldest word, and that word is removed at the clock edge.
- R3: A bus read of offset 0x20 returns the oldest received word and removes it. A read of an empty receive queue returns zero and leaves the level at zero.
- R4: If `eng_tx_req` is high, `eng_tx_mode` is high and the transmit queue is empty at a clock edge, status bit 4 is set. The same request with `eng_tx_mode` low sets nothing.
- R5: If `eng_rx_valid` is high while the receive queue holds DEPTH words, status bit 5 is set and the delivered word is discarded.
- R6: Register 0x14 holds the transmit threshold in bits [3:0] and the receive threshold in bits [7:4], and resets to 0x80. At every clock edge status bit 2 is set if the transmit level is at or below its threshold, and status bit 3 is set if the receive level is at or above its threshold.
- R7: A high `eng_done` at a clock edge sets status bit 1. Status bit 0 (read at 0x0C) shows `eng_busy` directly and is never changed by bus writes.
- R8: A bus write to 0x0C clears each status bit in [5:1] whose written bit is one. If a bit is cleared and set in the same cycle, the set wins.
- R9: Register 0x10 holds five enables. Bit 0 enables done, bit 1 the transmit threshold, bit 2 the receive threshold, bit 3 underflow and bit 4 overflow. `irq` is high exactly when some enabled event bit is set. Status bit 0 never raises `irq`.
- R10: After reset the status, enables and levels read zero and the threshold reads 0x80. Reads of offsets not listed here, including 0x00, 0x04, 0x08 and 0x1C, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on receive data offset) |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data for `bus_addr` |
| eng_busy | input | 1 | Engine has a command in progress |
| eng_tx_mode | input | 1 | Current command transmits data |
| eng_tx_req | input | 1 | Engine requests a transmit word |
| eng_tx_ack | output | 1 | Requested word is present this cycle |
| eng_tx_word | output | DW | Oldest transmit word |
| eng_rx_valid | input | 1 | Engine delivers a received word |
| eng_rx_word | input | DW | Received word |
| eng_done | input | 1 | Transfer finished pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters, DEPTH 8 and DW 32. The shallow queue means full and empty are each only a few strobes away. A random mix of pushes, pulls, pops and deliveries therefore crosses the overflow, underflow, full-push and empty-pop boundaries many times. Because the level fields are four bits wide, randomly written thresholds from 0 to 15 cover the cases where a threshold condition always holds, never holds, or holds only at the exact full or empty level.

// File: rtl/spi_wq_pkg.sv
`timescale 1ns/1ps
package spi_wq_pkg;
    // Register byte offsets on the 6-bit bus
    localparam int          REG_AW    = 6;
    localparam logic [5:0]  A_STATUS  = 6'h0C;
    localparam logic [5:0]  A_IEN     = 6'h10;
    localparam logic [5:0]  A_THR     = 6'h14;
    localparam logic [5:0]  A_LEVEL   = 6'h18;
    localparam logic [5:0]  A_TXD     = 6'h1C;
    localparam logic [5:0]  A_RXD     = 6'h20;

    // Width of each packed level / threshold field
    localparam int          LVL_W     = 4;
    localparam logic [2*LVL_W-1:0] THR_RESET = 8'h80;

    // Number of sticky events (status bits 1..NUM_EV)
    localparam int          NUM_EV    = 5;

    // Event index inside the sticky vector (status bit = index + 1)
    localparam int          EV_DONE   = 0;
    localparam int          EV_TXTH   = 1;
    localparam int          EV_RXTH   = 2;
    localparam int          EV_TXUF   = 3;
    localparam int          EV_RXOF   = 4;
endpackage

// File: rtl/wq_fifo.sv
`timescale 1ns/1ps
module wq_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            push,
    input  logic                            pop,
    input  logic [DW-1:0]                   wdata,
    output logic [DW-1:0]                   head,
    output logic [$clog2(DEPTH+1)-1:0]      level,
    output logic                            full,
    output logic                            empty
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;
    logic          push_ok, pop_ok;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign push_ok = push & ~full;   // full push dropped (R2, R5)
    assign pop_ok  = pop & ~empty;   // empty pop harmless (R3)
    assign level   = cnt_q;
    assign head    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/wq_events.sv
`timescale 1ns/1ps
module wq_events #(
    parameter int NEV = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] set_ev,
    input  logic [NEV-1:0] clr_ev,
    input  logic [NEV-1:0] enable,
    output logic [NEV-1:0] ev_q,
    output logic           irq
);
    // One sticky flop per event; a set in the clearing cycle wins (R8)
    for (genvar i = 0; i < NEV; i++) begin : g_ev
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ev_q[i] <= 1'b0;
            end else if (set_ev[i]) begin
                ev_q[i] <= 1'b1;
            end else if (clr_ev[i]) begin
                ev_q[i] <= 1'b0;
            end
        end
    end

    // R9: enabled sticky events only; the busy bit never reaches here
    assign irq = |(ev_q & enable);
endmodule

// File: rtl/spi_wordq_status.sv
`timescale 1ns/1ps
module spi_wordq_status
    import spi_wq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [5:0]        bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              eng_busy,
    input  logic              eng_tx_mode,
    input  logic              eng_tx_req,
    output logic              eng_tx_ack,
    output logic [DW-1:0]     eng_tx_word,
    input  logic              eng_rx_valid,
    input  logic [DW-1:0]     eng_rx_word,
    input  logic              eng_done,
    output logic              irq
);
    localparam int CW = $clog2(DEPTH+1);

    logic [CW-1:0]        tx_level, rx_level;
    logic                 tx_full, tx_empty, rx_full, rx_empty;
    logic [DW-1:0]        tx_head, rx_head;
    logic [NUM_EV-1:0]    ien_q, ev_q, ev_set, ev_clr;
    logic [2*LVL_W-1:0]   thr_q;
    logic [LVL_W-1:0]     tx_lvl_f, rx_lvl_f;
    logic [NUM_EV:0]      stat_vec;
    logic                 wr_status, wr_ien, wr_thr, wr_txd, rd_rxd;

    assign wr_status = bus_wr && (bus_addr == A_STATUS);
    assign wr_ien    = bus_wr && (bus_addr == A_IEN);
    assign wr_thr    = bus_wr && (bus_addr == A_THR);
    assign wr_txd    = bus_wr && (bus_addr == A_TXD);
    assign rd_rxd    = bus_rd && (bus_addr == A_RXD);

    // Transmit queue: bus pushes, engine pulls (R2)
    wq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_txd),
        .pop   (eng_tx_req),
        .wdata (bus_wdata),
        .head  (tx_head),
        .level (tx_level),
        .full  (tx_full),
        .empty (tx_empty)
    );

    // Receive queue: engine delivers, bus pops (R3, R5)
    wq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (eng_rx_valid),
        .pop   (rd_rxd),
        .wdata (eng_rx_word),
        .head  (rx_head),
        .level (rx_level),
        .full  (rx_full),
        .empty (rx_empty)
    );

    assign eng_tx_ack  = eng_tx_req & ~tx_empty;
    assign eng_tx_word = tx_head;

    assign tx_lvl_f = LVL_W'(tx_level);
    assign rx_lvl_f = LVL_W'(rx_level);

    // Event sources (R4, R5, R6, R7)
    always_comb begin
        ev_set           = '0;
        ev_set[EV_DONE]  = eng_done;
        ev_set[EV_TXTH]  = (tx_lvl_f <= thr_q[LVL_W-1:0]);
        ev_set[EV_RXTH]  = (rx_lvl_f >= thr_q[2*LVL_W-1:LVL_W]);
        ev_set[EV_TXUF]  = eng_tx_req & eng_tx_mode & tx_empty;
        ev_set[EV_RXOF]  = eng_rx_valid & rx_full;
    end

    assign ev_clr = wr_status ? bus_wdata[NUM_EV:1] : '0;

    wq_events #(.NEV(NUM_EV)) u_ev (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (ev_set),
        .clr_ev (ev_clr),
        .enable (ien_q),
        .ev_q   (ev_q),
        .irq    (irq)
    );

    // Control registers (R6, R9, R10)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q <= '0;
            thr_q <= THR_RESET;
        end else begin
            if (wr_ien) ien_q <= bus_wdata[NUM_EV-1:0];
            if (wr_thr) thr_q <= bus_wdata[2*LVL_W-1:0];
        end
    end

    assign stat_vec = {ev_q, eng_busy};

    // Read path (R1, R3, R7, R10)
    always_comb begin
        unique case (bus_addr)
            A_STATUS: bus_rdata = DW'(stat_vec);
            A_IEN:    bus_rdata = DW'(ien_q);
            A_THR:    bus_rdata = DW'(thr_q);
            A_LEVEL:  bus_rdata = DW'({tx_lvl_f, rx_lvl_f});
            A_RXD:    bus_rdata = rx_head;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wq_checker.sv
`timescale 1ns/1ps
module wq_checker
    import spi_wq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [5:0]    bus_addr,
    input logic          clr_done,
    input logic          eng_tx_req,
    input logic          eng_tx_mode,
    input logic          eng_tx_ack,
    input logic          eng_rx_valid,
    input logic          eng_done,
    input logic          irq,
    input logic [CW-1:0] tx_level,
    input logic [CW-1:0] rx_level,
    input logic [5:0]    stat_vec
);
    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= CW'(DEPTH)) && (rx_level <= CW'(DEPTH)));

    assert_ack_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_tx_ack |-> (tx_level != '0));

    assert_full_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_TXD && tx_level == CW'(DEPTH) && !eng_tx_ack)
        |=> (tx_level == CW'(DEPTH)));

    assert_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_req && eng_tx_mode && tx_level == '0) |=> stat_vec[4]);

    assert_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_valid && rx_level == CW'(DEPTH)) |=> stat_vec[5]);

    assert_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> stat_vec[1]);

    assert_w1c_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_STATUS && clr_done && !eng_done) |=> !stat_vec[1]);

    assert_quiet_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vec[5:1] == 5'd0) |-> !irq);
endmodule

bind spi_wordq_status wq_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .clr_done     (bus_wdata[1]),
    .eng_tx_req   (eng_tx_req),
    .eng_tx_mode  (eng_tx_mode),
    .eng_tx_ack   (eng_tx_ack),
    .eng_rx_valid (eng_rx_valid),
    .eng_done     (eng_done),
    .irq          (irq),
    .tx_level     (tx_level),
    .rx_level     (rx_level),
    .stat_vec     (stat_vec)
);

// File: tb/sim_spi_wordq_status.sv
`timescale 1ns/1ps
module sim_spi_wordq_status;
    localparam int DEPTH_TB = 8;
    localparam logic [5:0] O_STATUS = 6'h0C, O_IEN = 6'h10, O_THR = 6'h14,
                           O_LEVEL = 6'h18, O_TXD = 6'h1C, O_RXD = 6'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_busy = 1'b0, eng_tx_mode = 1'b0, eng_tx_req = 1'b0;
    logic        eng_tx_ack;
    logic [31:0] eng_tx_word;
    logic        eng_rx_valid = 1'b0;
    logic [31:0] eng_rx_word = '0;
    logic        eng_done = 1'b0;
    logic        irq;

    always #2.5 clk = ~clk;

    spi_wordq_status u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_busy(eng_busy), .eng_tx_mode(eng_tx_mode), .eng_tx_req(eng_tx_req),
        .eng_tx_ack(eng_tx_ack), .eng_tx_word(eng_tx_word),
        .eng_rx_valid(eng_rx_valid), .eng_rx_word(eng_rx_word),
        .eng_done(eng_done), .irq(irq)
    );

    int nchk = 0, nerr = 0;
    logic busy_v = 1'b0, txm_v = 1'b0;
    logic [5:0]  mst = '0;
    logic [4:0]  mien = '0;
    logic [7:0]  mthr = 8'h80;
    logic [31:0] mtx[$];
    logic [31:0] mrx[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [5:0] a);
        case (a)
            O_STATUS: return {26'd0, mst[5:1], busy_v};
            O_IEN:    return {27'd0, mien};
            O_THR:    return {24'd0, mthr};
            O_LEVEL:  return {24'd0, 4'(mtx.size()), 4'(mrx.size())};
            O_RXD:    return (mrx.size() > 0) ? mrx[0] : 32'd0;
            default:  return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] a);
        case (a)
            O_STATUS: return "R6 R7 R8 status read";
            O_LEVEL:  return "R1 level read";
            O_RXD:    return "R3 rx data read";
            default:  return "R10 register read";
        endcase
    endfunction

    // One clock cycle: drive at negedge, check, advance model, cross posedge
    task automatic step(input logic wr, input logic rd, input logic [5:0] a,
                        input logic [31:0] wd, input logic rxv, input logic [31:0] rxw,
                        input logic treq, input logic dn,
                        output logic [31:0] rv, output logic ack, output logic [31:0] tw);
        logic [5:0] set, clr;
        int ts, rs;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        eng_rx_valid = rxv; eng_rx_word = rxw; eng_tx_req = treq; eng_done = dn;
        eng_busy = busy_v; eng_tx_mode = txm_v;
        #1;
        rv = bus_rdata; ack = eng_tx_ack; tw = eng_tx_word;
        ts = mtx.size(); rs = mrx.size();
        if (rd) check(tag_of(a), rv, exp_read(a));
        check("R9 irq", 32'(irq), 32'(|(mst[5:1] & mien)));
        check("R2 tx ack", 32'(ack), 32'(treq && ts > 0));
        if (treq && ts > 0) check("R2 tx word", tw, mtx[0]);
        set = '0;
        set[1] = dn;
        set[2] = (ts <= int'(mthr[3:0]));
        set[3] = (rs >= int'(mthr[7:4]));
        set[4] = treq && txm_v && (ts == 0);
        set[5] = rxv && (rs == DEPTH_TB);
        clr = (wr && a == O_STATUS) ? wd[5:0] : 6'd0;
        mst = ((mst & ~clr) | set) & 6'h3E;
        if (wr && a == O_IEN) mien = wd[4:0];
        if (wr && a == O_THR) mthr = wd[7:0];
        if (treq && ts > 0) void'(mtx.pop_front());
        if (wr && a == O_TXD && ts < DEPTH_TB) mtx.push_back(wd);
        if (rxv && rs < DEPTH_TB) mrx.push_back(rxw);
        if (rd && a == O_RXD && rs > 0) void'(mrx.pop_front());
        @(posedge clk);
    endtask

    logic [31:0] t_rv, t_tw;
    logic        t_ack;

    task automatic bw(input logic [5:0] a, input logic [31:0] d);
        step(1'b1, 1'b0, a, d, 1'b0, 32'd0, 1'b0, 1'b0, t_rv, t_ack, t_tw);
    endtask
    task automatic br(input logic [5:0] a, output logic [31:0] v);
        step(1'b0, 1'b1, a, 32'd0, 1'b0, 32'd0, 1'b0, 1'b0, v, t_ack, t_tw);
    endtask
    task automatic epush(input logic [31:0] w);
        step(1'b0, 1'b0, 6'd0, 32'd0, 1'b1, w, 1'b0, 1'b0, t_rv, t_ack, t_tw);
    endtask
    task automatic epull(output logic ack, output logic [31:0] w);
        step(1'b0, 1'b0, 6'd0, 32'd0, 1'b0, 32'd0, 1'b1, 1'b0, t_rv, ack, w);
    endtask
    task automatic edone();
        step(1'b0, 1'b0, 6'd0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b1, t_rv, t_ack, t_tw);
    endtask
    task automatic idle();
        step(1'b0, 1'b0, 6'd0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b0, t_rv, t_ack, t_tw);
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v, w;
        logic        a;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset values
        br(O_STATUS, v); check("R10 reset status", v, 32'h0);
        br(O_LEVEL, v);  check("R10 reset level", v, 32'h0);
        br(O_THR, v);    check("R10 reset threshold", v, 32'h80);
        br(O_IEN, v);    check("R10 reset enables", v, 32'h0);
        // R6 transmit threshold with empty queue
        br(O_STATUS, v); check("R6 tx threshold at level 0", v, 32'h04);
        // R8 set wins over clear
        bw(O_STATUS, 32'h3E);
        br(O_STATUS, v); check("R8 set beats clear", v, 32'h04);
        // R1 and R8
        for (int i = 0; i < 3; i++) bw(O_TXD, 32'hA000_0000 + i);
        bw(O_STATUS, 32'h04);
        br(O_STATUS, v); check("R8 cleared bit 2", v, 32'h0);
        br(O_LEVEL, v);  check("R1 tx level 3", v, 32'h30);
        // R7 busy bit is live and read-only
        busy_v = 1'b1;
        br(O_STATUS, v); check("R7 busy shown", v, 32'h01);
        bw(O_STATUS, 32'h3F);
        br(O_STATUS, v); check("R7 busy not cleared", v, 32'h01);
        busy_v = 1'b0;
        // R2 order
        txm_v = 1'b1;
        for (int i = 0; i < 3; i++) begin
            epull(a, w);
            check("R2 pulled word order", w, 32'hA000_0000 + i);
        end
        // R4 underflow
        epull(a, w); check("R4 no ack on empty", 32'(a), 32'd0);
        br(O_STATUS, v); check("R4 underflow set", v, 32'h14);
        bw(O_STATUS, 32'h3F);
        txm_v = 1'b0;
        epull(a, w);
        br(O_STATUS, v); check("R4 no underflow outside tx mode", v, 32'h04);
        // R2 full push ignored
        for (int i = 0; i < 9; i++) bw(O_TXD, 32'hB000_0000 + i);
        br(O_LEVEL, v); check("R2 tx level capped", v, 32'h80);
        for (int i = 0; i < 9; i++) begin
            epull(a, w);
            check("R2 full push ack", 32'(a), (i < 8) ? 32'd1 : 32'd0);
            if (i < 8) check("R2 full push data", w, 32'hB000_0000 + i);
        end
        // R5 overflow, R3 order and empty pop
        for (int i = 0; i < 9; i++) epush(32'hC000_0000 + i);
        br(O_LEVEL, v);  check("R5 rx level capped", v, 32'h08);
        br(O_STATUS, v); check("R5 overflow and rx threshold", v, 32'h2C);
        for (int i = 0; i < 9; i++) begin
            br(O_RXD, v);
            check("R3 popped word", v, (i < 8) ? 32'hC000_0000 + i : 32'd0);
        end
        br(O_LEVEL, v); check("R3 empty pop keeps level", v, 32'h0);
        // R7 done
        bw(O_STATUS, 32'h3F);
        edone();
        br(O_STATUS, v); check("R7 done set", v, 32'h06);
        // R9 interrupt mapping
        bw(O_TXD, 32'hD000_0000);
        bw(O_STATUS, 32'h3F);
        busy_v = 1'b1;
        bw(O_IEN, 32'h1F);
        idle();
        #1 check("R9 busy does not interrupt", 32'(irq), 32'd0);
        edone();
        #1 check("R9 done interrupts", 32'(irq), 32'd1);
        busy_v = 1'b0;
        bw(O_IEN, 32'h08);
        bw(O_STATUS, 32'h3F);
        #1 check("R9 quiet after clear", 32'(irq), 32'd0);
        txm_v = 1'b1;
        epull(a, w);
        epull(a, w);
        #1 check("R9 underflow interrupts", 32'(irq), 32'd1);
        txm_v = 1'b0;
        // R6 receive threshold at 3
        bw(O_IEN, 32'h0);
        bw(O_THR, 32'h32);
        bw(O_STATUS, 32'h3F);
        epush(32'hE000_0000);
        epush(32'hE000_0001);
        br(O_STATUS, v); check("R6 rx below threshold", v & 32'h08, 32'h0);
        epush(32'hE000_0002);
        idle();
        br(O_STATUS, v); check("R6 rx at threshold", v & 32'h08, 32'h08);
        for (int i = 0; i < 3; i++) br(O_RXD, v);
        // R10 unmapped reads
        br(6'h00, v); check("R10 offset 0x00", v, 32'h0);
        br(6'h04, v); check("R10 offset 0x04", v, 32'h0);
        br(6'h08, v); check("R10 offset 0x08", v, 32'h0);
        br(6'h1C, v); check("R10 offset 0x1C", v, 32'h0);
        bw(O_THR, 32'h80);

        // Constrained random mix, checked every cycle against the model
        for (int n = 0; n < 1500; n++) begin
            int k;
            logic dn;
            k  = $urandom_range(0, 12);
            dn = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 31) == 0) txm_v = ~txm_v;
            if ($urandom_range(0, 31) == 0) busy_v = ~busy_v;
            case (k)
                0, 1:    step(1'b1, 1'b0, O_TXD, $urandom, 1'b0, 32'd0, 1'b0, dn, t_rv, t_ack, t_tw);
                2, 3:    step(1'b0, 1'b0, 6'd0, 32'd0, 1'b0, 32'd0, 1'b1, dn, t_rv, t_ack, t_tw);
                4, 5:    step(1'b0, 1'b0, 6'd0, 32'd0, 1'b1, $urandom, 1'b0, dn, t_rv, t_ack, t_tw);
                6, 7:    step(1'b0, 1'b1, O_RXD, 32'd0, 1'b0, 32'd0, 1'b0, dn, t_rv, t_ack, t_tw);
                8:       step(1'b0, 1'b1, O_LEVEL, 32'd0, 1'b0, 32'd0, 1'b0, dn, t_rv, t_ack, t_tw);
                9:       step(1'b0, 1'b1, O_STATUS, 32'd0, 1'b0, 32'd0, 1'b0, dn, t_rv, t_ack, t_tw);
                10:      step(1'b1, 1'b0, O_STATUS, $urandom, 1'b0, 32'd0, 1'b0, dn, t_rv, t_ack, t_tw);
                11:      step(1'b1, 1'b0, O_THR, $urandom, 1'b0, 32'd0, 1'b0, dn, t_rv, t_ack, t_tw);
                default: step(1'b1, 1'b0, O_IEN, $urandom, 1'b0, 32'd0, 1'b0, dn, t_rv, t_ack, t_tw);
            endcase
        end
        idle();
        summary();
        $finish;
    end
endmodule